// File: doc/BRIEF.md
# Motion-Lamp Output Timer and Driver

This block turns validated motion events into a lamp drive. Each accepted trigger switches the lamp state on. In normal operation the lamp stays on for a fixed number of delay-oscillator ticks. In test mode it stays on for a fixed number of system clocks that stand for two seconds. A trigger that arrives while the lamp is already on restarts the on-period from its full length. Two requests from the mode controller take priority over triggers: one forces the lamp on and the other forces it off.

Triggers are accepted only at night. The block follows a light-sensor level, where high means dark. Motion detection is enabled only after that level has stayed high for a debounce window. When the level goes low, detection is disabled at once.

The lamp state leaves the block in one of two drive styles, chosen by a parameter. The relay style is an active-high level. The triac style is an active-low pin that pulses for a fixed number of clocks after each line zero-cross strobe while the lamp is on, and rests high otherwise. All inputs are synchronous to `clk_i`. Strobes are one clock wide.

Top module: `lamp_drive_top`

## Requirements
- R1: While `rst_ni` is low, and after its release until a trigger or request acts, `relay_o` is 0 and `triac_o` is 1. The night gate starts disabled.
- R2: With DRIVE_STYLE = STYLE_RELAY, `relay_o` equals the lamp state and `triac_o` is held at 1.
- R3: With DRIVE_STYLE = STYLE_TRIAC, `relay_o` is held at 0. A `zc_i` strobe sampled while the lamp is on drives `triac_o` low for exactly PULSE_CLKS clocks, starting after that edge. A new strobe restarts the pulse.
- R4: When `test_i` is 0, an accepted trigger turns the lamp on from the edge that samples it. The lamp turns off at the edge that samples the AUTO_TICKS-th later `dtick_i` strobe. A tick sampled at the trigger edge is not counted.
- R5: When `test_i` is 1 at the accepted trigger, the lamp stays on for exactly TEST_CLKS clocks, and `dtick_i` has no effect.
- R6: An accepted trigger while the lamp is on reloads the full on-period.
- R7: The night gate enables only after `light_i` has been sampled high on NIGHT_CLKS consecutive edges. Triggers sampled before that are ignored.
- R8: An edge that samples `light_i` low disables the gate. A trigger at any later edge is ignored until R7 is met again.
- R9: While `force_off_i` is 1, the lamp is off and triggers are ignored. The running on-period is discarded, so the lamp stays off after release.
- R10: While `force_on_i` is 1 and `force_off_i` is 0, the lamp is on and triggers are ignored. After release the lamp is off until the next accepted trigger.
- R11: In triac style, no pulse starts while the lamp is off. A running pulse ends one edge after the lamp state goes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Valid motion trigger strobe |
| dtick_i | input | 1 | Delay-oscillator tick strobe |
| zc_i | input | 1 | Line zero-cross strobe |
| light_i | input | 1 | Light-sensor level, high means night |
| test_i | input | 1 | Test-mode flag from the mode controller |
| force_on_i | input | 1 | Forced-on request |
| force_off_i | input | 1 | Forced-off request, dominant |
| relay_o | output | 1 | Relay-style drive, active high |
| triac_o | output | 1 | Triac-style drive, active-low pulses |

## Verification
The bench counts the dark samples needed before a trigger is taken, checking that NIGHT_CLKS is met exactly. A gate that is off by one, or that fails to clear its count when the light dips, would accept an early trigger or reject a valid one. It also counts delay ticks and test-mode clocks up to the end of the on-period, before and after a retrigger. An off-by-one expiry or a missing reload would change those counts. Forced requests are applied around running on-periods, and triac pulses are started and then cut off by a lamp turn-off. A design that kept the old timer, or left a pulse hanging, would light the lamp after release or pull the triac pin low while the lamp is off.

// File: rtl/lamp_drive_pkg.sv
package lamp_drive_pkg;

   typedef enum logic {
      STYLE_RELAY = 1'b0,
      STYLE_TRIAC = 1'b1
   } drive_style_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/night_gate.sv
module night_gate #(
   parameter int unsigned NIGHT_CLKS = 80000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic light_i,
   output logic night_o
);
   localparam int unsigned NW = lamp_drive_pkg::cnt_width(NIGHT_CLKS);
   localparam logic [NW-1:0] LAST = NW'(NIGHT_CLKS - 1);

   logic [NW-1:0] dark_cnt_q;
   logic          night_q;

   generate
      if (NIGHT_CLKS < 1) begin : g_bad_night
         initial $fatal(1, "night_gate: NIGHT_CLKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         dark_cnt_q <= '0;
         night_q    <= 1'b0;
      end else if (!light_i) begin
         dark_cnt_q <= '0;
         night_q    <= 1'b0;
      end else if (!night_q) begin
         if (dark_cnt_q == LAST) begin
            night_q <= 1'b1;
         end else begin
            dark_cnt_q <= dark_cnt_q + 1'b1;
         end
      end
   end

   assign night_o = night_q;

   AST_DAY_DROPS_AT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !light_i |=> !night_o); // R8
   AST_NIGHT_NEEDS_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(night_o) |-> $past(light_i)); // R7

endmodule

// File: rtl/on_timer.sv
module on_timer #(
   parameter int unsigned AUTO_TICKS = 96,
   parameter int unsigned TEST_CLKS  = 32000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   input  logic dtick_i,
   input  logic test_i,
   input  logic night_i,
   input  logic force_on_i,
   input  logic force_off_i,
   output logic lamp_o
);
   localparam int unsigned CW = lamp_drive_pkg::cnt_width(
                                   lamp_drive_pkg::max_u(AUTO_TICKS, TEST_CLKS));
   localparam logic [CW-1:0] AUTO_LOAD = CW'(AUTO_TICKS);
   localparam logic [CW-1:0] TEST_LOAD = CW'(TEST_CLKS);
   localparam logic [CW-1:0] ONE       = CW'(1);

   logic [CW-1:0] rem_q, rem_d;
   logic          test_q, test_d;
   logic          lamp_q, lamp_d;
   logic          take_trig;
   logic          dec_en;

   generate
      if (AUTO_TICKS < 1) begin : g_bad_auto
         initial $fatal(1, "on_timer: AUTO_TICKS must be at least 1");
      end
      if (TEST_CLKS < 1) begin : g_bad_test
         initial $fatal(1, "on_timer: TEST_CLKS must be at least 1");
      end
   endgenerate

   assign take_trig = trig_i & night_i;
   assign dec_en    = test_q | dtick_i;

   always_comb begin
      rem_d  = rem_q;
      test_d = test_q;
      lamp_d = (rem_q != '0);
      if (force_off_i) begin
         rem_d  = '0;
         lamp_d = 1'b0;
      end else if (force_on_i) begin
         rem_d  = '0;
         lamp_d = 1'b1;
      end else if (take_trig) begin
         rem_d  = test_i ? TEST_LOAD : AUTO_LOAD;
         test_d = test_i;
         lamp_d = 1'b1;
      end else if ((rem_q != '0) && dec_en) begin
         rem_d  = rem_q - ONE;
         lamp_d = (rem_q != ONE);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         test_q <= 1'b0;
         lamp_q <= 1'b0;
      end else begin
         rem_q  <= rem_d;
         test_q <= test_d;
         lamp_q <= lamp_d;
      end
   end

   assign lamp_o = lamp_q;

   AST_FORCE_OFF_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_off_i |=> !lamp_o); // R9
   AST_FORCE_ON_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (force_on_i && !force_off_i) |=> lamp_o); // R10
   AST_TRIG_LIGHTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i && night_i && !force_off_i) |=> lamp_o); // R4
   AST_DAY_TRIG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lamp_o && !night_i && !force_on_i) |=> !lamp_o); // R7

endmodule

// File: rtl/triac_pulser.sv
module triac_pulser #(
   parameter int unsigned PULSE_CLKS = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lamp_i,
   input  logic zc_i,
   output logic triac_o
);
   localparam int unsigned PW = lamp_drive_pkg::cnt_width(PULSE_CLKS);
   localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CLKS);

   logic [PW-1:0] pulse_q;

   generate
      if (PULSE_CLKS < 1) begin : g_bad_pulse
         initial $fatal(1, "triac_pulser: PULSE_CLKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pulse_q <= '0;
      end else if (!lamp_i) begin
         pulse_q <= '0;
      end else if (zc_i) begin
         pulse_q <= PULSE_LOAD;
      end else if (pulse_q != '0) begin
         pulse_q <= pulse_q - 1'b1;
      end
   end

   assign triac_o = (pulse_q == '0);

   AST_PULSE_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zc_i && lamp_i) |=> !triac_o); // R3
   AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lamp_i |=> triac_o); // R11

endmodule

// File: rtl/lamp_drive_top.sv
module lamp_drive_top #(
   parameter lamp_drive_pkg::drive_style_e DRIVE_STYLE = lamp_drive_pkg::STYLE_TRIAC,
   parameter int unsigned NIGHT_CLKS = 80000,
   parameter int unsigned AUTO_TICKS = 96,
   parameter int unsigned TEST_CLKS  = 32000,
   parameter int unsigned PULSE_CLKS = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   input  logic dtick_i,
   input  logic zc_i,
   input  logic light_i,
   input  logic test_i,
   input  logic force_on_i,
   input  logic force_off_i,
   output logic relay_o,
   output logic triac_o
);
   logic night_en;
   logic lamp_on;

   night_gate #(
      .NIGHT_CLKS(NIGHT_CLKS)
   ) i_night_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .light_i(light_i),
      .night_o(night_en)
   );

   on_timer #(
      .AUTO_TICKS(AUTO_TICKS),
      .TEST_CLKS (TEST_CLKS)
   ) i_on_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trig_i     (trig_i),
      .dtick_i    (dtick_i),
      .test_i     (test_i),
      .night_i    (night_en),
      .force_on_i (force_on_i),
      .force_off_i(force_off_i),
      .lamp_o     (lamp_on)
   );

   generate
      if (DRIVE_STYLE == lamp_drive_pkg::STYLE_TRIAC) begin : g_triac
         triac_pulser #(
            .PULSE_CLKS(PULSE_CLKS)
         ) i_triac_pulser (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .lamp_i (lamp_on),
            .zc_i   (zc_i),
            .triac_o(triac_o)
         );
         assign relay_o = 1'b0;
      end else begin : g_relay
         assign relay_o = lamp_on;
         assign triac_o = 1'b1;
         AST_RELAY_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            force_off_i |=> !relay_o); // R2
      end
   endgenerate

endmodule

// File: tb/test_lamp_drive_top.sv
module test_lamp_drive_top;
   localparam int unsigned NIGHT = 8;
   localparam int unsigned AUTO  = 3;
   localparam int unsigned TEST  = 10;
   localparam int unsigned PULSE = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0, dtick = 1'b0, zc = 1'b0, light = 1'b0;
   logic test = 1'b0, fon = 1'b0, foff = 1'b0;
   logic relay_r, triac_r, relay_t, triac_t;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lamp_drive_top #(
      .DRIVE_STYLE(lamp_drive_pkg::STYLE_RELAY), .NIGHT_CLKS(NIGHT),
      .AUTO_TICKS(AUTO), .TEST_CLKS(TEST), .PULSE_CLKS(PULSE)
   ) i_lamp_drive_top (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .dtick_i(dtick), .zc_i(zc),
      .light_i(light), .test_i(test), .force_on_i(fon), .force_off_i(foff),
      .relay_o(relay_r), .triac_o(triac_r)
   );

   lamp_drive_top #(
      .DRIVE_STYLE(lamp_drive_pkg::STYLE_TRIAC), .NIGHT_CLKS(NIGHT),
      .AUTO_TICKS(AUTO), .TEST_CLKS(TEST), .PULSE_CLKS(PULSE)
   ) i_lamp_drive_top_triac (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .dtick_i(dtick), .zc_i(zc),
      .light_i(light), .test_i(test), .force_on_i(fon), .force_off_i(foff),
      .relay_o(relay_t), .triac_o(triac_t)
   );

   // Reference model built from the requirements
   int m_dark = 0, m_rem = 0, m_pc = 0;
   bit m_night = 0, m_tq = 0, m_lamp = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dark = 0; m_night = 0; m_rem = 0; m_tq = 0; m_lamp = 0; m_pc = 0;
      end else begin
         // R3 / R11 pulse follows the lamp state held before this edge
         if (!m_lamp) m_pc = 0;
         else if (zc) m_pc = PULSE;
         else if (m_pc != 0) m_pc = m_pc - 1;
         // R4 R5 R6 R9 R10 lamp state
         if (foff) begin m_rem = 0; m_lamp = 0; end
         else if (fon) begin m_rem = 0; m_lamp = 1; end
         else if (trig && m_night) begin
            m_rem = test ? TEST : AUTO; m_tq = test; m_lamp = 1;
         end else if (m_rem != 0 && (m_tq || dtick)) begin
            m_rem = m_rem - 1; m_lamp = (m_rem != 0);
         end else m_lamp = (m_rem != 0);
         // R7 / R8 night gate
         if (!light) begin m_dark = 0; m_night = 0; end
         else if (!m_night) begin
            if (m_dark == NIGHT - 1) m_night = 1;
            else m_dark = m_dark + 1;
         end
      end
   end

   function automatic bit exp_triac();
      return (m_pc == 0);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      check("R2 relay level", relay_r, m_lamp);
      check("R2 relay-style triac idle", triac_r, 1'b1);
      check("R3 triac pin", triac_t, exp_triac());
      check("R3 triac-style relay idle", relay_t, 1'b0);
   endtask

   task automatic pulse_trig();
      trig = 1'b1; tick(); trig = 1'b0;
   endtask

   task automatic make_night();
      light = 1'b1;
      repeat (NIGHT + 1) tick();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int cnt;
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      // R1 reset state
      repeat (3) tick();
      check("R1 relay in reset", relay_r, 1'b0);
      check("R1 triac in reset", triac_t, 1'b1);
      rst_n = 1'b1;
      tick();
      check("R1 relay after reset", relay_r, 1'b0);

      // R7 trigger in daylight and during debounce ignored
      pulse_trig();
      check("R7 day trigger ignored", relay_r, 1'b0);
      light = 1'b1;
      repeat (NIGHT - 1) tick();
      pulse_trig();
      check("R7 trigger one sample early ignored", relay_r, 1'b0);
      // gate now enabled (NIGHT samples taken), trigger is taken
      pulse_trig();
      check("R7 trigger after debounce taken", relay_r, 1'b1);
      repeat (AUTO) begin dtick = 1'b1; tick(); dtick = 1'b0; tick(); end
      check("R4 off after ticks", relay_r, 1'b0);

      // R4 count ticks to expiry
      pulse_trig();
      cnt = 0;
      while (relay_r && cnt < 50) begin
         dtick = 1'b1; tick(); dtick = 1'b0; cnt++; tick();
      end
      check_int("R4 ticks in on-period", cnt, AUTO);

      // R6 retrigger reloads
      pulse_trig();
      repeat (AUTO - 1) begin dtick = 1'b1; tick(); dtick = 1'b0; end
      pulse_trig();
      cnt = 0;
      while (relay_r && cnt < 50) begin
         dtick = 1'b1; tick(); dtick = 1'b0; cnt++;
      end
      check_int("R6 ticks after reload", cnt, AUTO);

      // R5 test mode fixed clocks, ticks ignored
      test = 1'b1; dtick = 1'b1;
      pulse_trig();
      cnt = 0;
      while (relay_r && cnt < 100) begin cnt++; tick(); end
      check_int("R5 test on-clocks", cnt, TEST);
      test = 1'b0; dtick = 1'b0;

      // R9 force off dominates and discards timer
      pulse_trig();
      foff = 1'b1; tick();
      check("R9 forced off", relay_r, 1'b0);
      pulse_trig();
      check("R9 trigger under force off", relay_r, 1'b0);
      foff = 1'b0; tick();
      check("R9 stays off after release", relay_r, 1'b0);

      // R10 force on, and R3 pulse width
      fon = 1'b1; tick();
      check("R10 forced on", relay_r, 1'b1);
      zc = 1'b1; tick(); zc = 1'b0;
      cnt = 0;
      while (!triac_t && cnt < 50) begin cnt++; tick(); end
      check_int("R3 pulse clocks", cnt, PULSE);
      pulse_trig();
      fon = 1'b0; tick();
      check("R10 off after release", relay_r, 1'b0);

      // R11 pulse cut by turn-off, no pulse while off
      fon = 1'b1; tick();
      zc = 1'b1; tick(); zc = 1'b0;
      fon = 1'b0; foff = 1'b1; tick();
      tick();
      check("R11 pulse ended after off", triac_t, 1'b1);
      foff = 1'b0;
      zc = 1'b1; tick(); zc = 1'b0;
      check("R11 no pulse while off", triac_t, 1'b1);

      // R8 day disables at once
      light = 1'b0; tick();
      light = 1'b1;
      pulse_trig();
      check("R8 trigger after day dip ignored", relay_r, 1'b0);
      make_night();

      // Random mix
      for (int i = 0; i < 4000; i++) begin
         light = ($urandom_range(99) < 98);
         trig  = ($urandom_range(99) < 6);
         dtick = ($urandom_range(99) < 30);
         zc    = ($urandom_range(99) < 12);
         if ($urandom_range(99) < 3) test = ~test;
         fon   = ($urandom_range(999) < 15);
         foff  = ($urandom_range(999) < 10);
         tick();
      end
      trig = 1'b0; dtick = 1'b0; zc = 1'b0; fon = 1'b0; foff = 1'b0;
      tick();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule